// File: doc/BRIEF.md
# Scaled Fractional-Nanosecond System Time Counter

This block keeps a 64-bit free-running time register that counts in scaled sub-nanosecond units. On every reference tick it adds a programmable fixed-point increment. The increment is chosen so that software gets nanoseconds by a plain right shift of the raw value, and the block reports that shift amount on `shift_o`. The reference tick is 6.4 ns at 10G or with no link, ten times longer at 1G and one hundred times longer at 100M. The default increment per speed compensates for this, so a given shift always yields nanoseconds.

The base increment for the current link speed can be trimmed by a signed parts-per-billion correction. Software can also write the increment register directly. The time value is loaded or cleared through 32-bit word writes. It is read as a low and a high word, and reading the low word captures the high word so that the pair is coherent. A parameter selects a wide variant with a 31-bit increment field or a narrow variant with a 24-bit field. In the narrow variant the defaults are scaled down by 2^7 and a fixed period marker sits at bit 24.

Top module: `sys_time_counter`

## Requirements
- R1: On a cycle with `tick_i` high and no clear or word write, the 64-bit time advances by the increment field (`inc_o` masked to the field width). With `tick_i` low and no clear or write, the time holds.
- R2: The time wraps modulo 2^64. For example, 0xFFFFFFFF_FFFFFFF0 plus 0x66666666 gives 0x00000000_66666656.
- R3: `speed_i` encodes 0 = 10G, 1 = 1G, 2 = 100M and 3 = no link, which behaves as 10G. With zero trim, the wide variant's `inc_o`/`shift_o` are 0x66666666/28 at 10G, 0x40000000/24 at 1G and 0x50000000/21 at 100M.
- R4: In the narrow variant (NARROW_INC=1), `inc_o` is the wide default shifted right by 7, held in bits 23:0, with bit 24 set and bits 31:25 clear. `shift_o` is the wide shift minus 7, giving 0x01CCCCCC/21 at 10G.
- R5: A ppb write sets the increment to base + base*|ppb|/1e9 for positive ppb and to base - base*|ppb|/1e9 for negative ppb, using integer truncation. The result applies from the cycle after the write.
- R6: The trim magnitude is limited to 250,000,000 ppb, so larger magnitudes give the same increment as that limit.
- R7: A direct increment write loads `inc_wdata_i` masked to the field width, plus the period bit in the narrow variant, and takes priority over a recompute in the same cycle. The increment then stays unchanged until the next increment write, ppb write or speed change.
- R8: `wr_lo_i` and `wr_hi_i` load their word of the time independently. `clr_i` zeroes all 64 bits. The priority is clear, then word write, then tick, and a write or clear suppresses that cycle's tick.
- R9: A `rd_lo_i` strobe captures the high word, and `rd_hi_o` shows that capture until the next strobe, whatever the time does meanwhile.
- R10: After reset the time is 0, `rd_hi_o` is 0, the increment is the 10G default and the shift is the 10G shift.
- R11: A speed change is applied at the edge where it is seen. A tick at that same edge still uses the old increment, and the accumulated time is kept: ticks A, A, A(with change to 1G), B give 3A+B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Reference tick enable |
| speed_i | input | 2 | Link speed code (0 10G, 1 1G, 2 100M, 3 no link) |
| ppb_we_i | input | 1 | Load a frequency trim |
| ppb_i | input | 32 | Signed trim in parts per billion |
| inc_we_i | input | 1 | Direct increment write |
| inc_wdata_i | input | 32 | Direct increment value |
| clr_i | input | 1 | Clear the time to zero |
| wr_lo_i | input | 1 | Write low time word |
| wr_hi_i | input | 1 | Write high time word |
| wdata_i | input | 32 | Time word write data |
| rd_lo_i | input | 1 | Low-word read strobe, captures high word |
| rd_lo_o | output | 32 | Current low time word |
| rd_hi_o | output | 32 | Captured high time word |
| inc_o | output | 32 | Active increment register |
| shift_o | output | 6 | Right shift that converts time to nanoseconds |

## Verification
Assertions check on every cycle that a tick adds exactly the active increment with modular wrap, that idle cycles hold the time, and that a clear gives zero. They also check that the captured high word matches the time at the strobe, that the increment stays put without an update source, that the trimmed value stays within a quarter of its base, and that the narrow period marker is set. The per-speed defaults, the exact truncated trim values and the clamp at the limit are shown only by the bench's scenarios. The same holds for the write and clear priority, the order in which a mid-run speed change takes effect, and the capture staying unchanged while the high word moves.

// File: rtl/sys_time_pkg.sv
package sys_time_pkg;
  typedef enum logic [1:0] {
    SPD_10G  = 2'd0,
    SPD_1G   = 2'd1,
    SPD_100M = 2'd2,
    SPD_NONE = 2'd3
  } speed_e;

  localparam logic [31:0] INC_10G   = 32'h6666_6666;
  localparam logic [31:0] INC_1G    = 32'h4000_0000;
  localparam logic [31:0] INC_100M  = 32'h5000_0000;
  localparam logic [5:0]  SHF_10G   = 6'd28;
  localparam logic [5:0]  SHF_1G    = 6'd24;
  localparam logic [5:0]  SHF_100M  = 6'd21;
  localparam int unsigned NARROW_DROP = 7;
  localparam int unsigned PPB_LIMIT   = 250_000_000;
endpackage

// File: rtl/stc_inc_defaults.sv
module stc_inc_defaults
  import sys_time_pkg::*;
#(
  parameter bit NARROW_INC = 1'b0
) (
  input  logic [1:0]  speed_i,
  output logic [31:0] base_o,
  output logic [5:0]  shift_o
);
  logic [31:0] wide_inc;
  logic [5:0]  wide_shf;

  always_comb begin
    unique case (speed_e'(speed_i))
      SPD_1G:   begin wide_inc = INC_1G;   wide_shf = SHF_1G;   end
      SPD_100M: begin wide_inc = INC_100M; wide_shf = SHF_100M; end
      default:  begin wide_inc = INC_10G;  wide_shf = SHF_10G;  end
    endcase
  end

  generate
    if (NARROW_INC) begin : g_narrow
      assign base_o  = wide_inc >> NARROW_DROP;
      assign shift_o = wide_shf - 6'(NARROW_DROP);
    end else begin : g_wide
      assign base_o  = wide_inc;
      assign shift_o = wide_shf;
    end
  endgenerate
endmodule

// File: rtl/stc_ppb_trim.sv
module stc_ppb_trim
  import sys_time_pkg::*;
#(
  parameter int unsigned PPB_W = 32
) (
  input  logic [31:0]      base_i,
  input  logic [PPB_W-1:0] ppb_i,
  output logic [31:0]      inc_o
);
  localparam logic [63:0] ONE_BILLION = 64'd1_000_000_000;
  localparam logic [PPB_W-1:0] LIMIT = PPB_W'(PPB_LIMIT);

  logic             neg;
  logic [PPB_W-1:0] mag_raw, mag;
  logic [63:0]      prod;
  logic [31:0]      diff;

  assign neg     = ppb_i[PPB_W-1];
  assign mag_raw = neg ? (~ppb_i + 1'b1) : ppb_i;
  // raw magnitude of the most negative code is 2^(W-1), still above the limit
  assign mag     = (mag_raw > LIMIT) ? LIMIT : mag_raw;
  assign prod    = 64'(base_i) * 64'(mag);
  assign diff    = 32'(prod / ONE_BILLION);
  assign inc_o   = neg ? (base_i - diff) : (base_i + diff);
endmodule

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned INC_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       inc_i,
  input  logic              rd_lo_i,
  output logic [31:0]       lo_o,
  output logic [31:0]       hi_o
);
  localparam int unsigned HALF_W = TIME_W / 2;
  localparam logic [31:0] FIELD_MASK = 32'((64'd1 << INC_W) - 64'd1);

  logic [TIME_W-1:0] time_q;
  logic [HALF_W-1:0] snap_q;
  logic [TIME_W-1:0] inc_add;
  logic              busy;

  assign inc_add = TIME_W'(inc_i & FIELD_MASK);
  assign busy    = clr_i | wr_lo_i | wr_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
    end else if (clr_i) begin
      time_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) time_q[HALF_W-1:0]      <= wdata_i;
      if (wr_hi_i) time_q[TIME_W-1:HALF_W] <= wdata_i;
    end else if (tick_i) begin
      time_q <= time_q + inc_add;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (rd_lo_i) snap_q <= time_q[TIME_W-1:HALF_W];
  end

  assign lo_o = time_q[HALF_W-1:0];
  assign hi_o = snap_q;

  AST_TICK_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy) |=> time_q == $past(time_q) + $past(inc_add)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !busy) |=> $stable(time_q)); // R1
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> time_q == '0); // R8
  AST_SNAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> hi_o == $past(time_q[TIME_W-1:HALF_W])); // R9
endmodule

// File: rtl/sys_time_counter.sv
module sys_time_counter
  import sys_time_pkg::*;
#(
  parameter bit          NARROW_INC = 1'b0,
  parameter int unsigned TIME_W     = 64,
  parameter int unsigned PPB_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        speed_i,
  input  logic              ppb_we_i,
  input  logic [PPB_W-1:0]  ppb_i,
  input  logic              inc_we_i,
  input  logic [31:0]       inc_wdata_i,
  input  logic              clr_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_lo_i,
  output logic [31:0]       rd_lo_o,
  output logic [31:0]       rd_hi_o,
  output logic [31:0]       inc_o,
  output logic [5:0]        shift_o
);
  localparam int unsigned INC_W      = NARROW_INC ? 24 : 31;
  localparam logic [31:0] FIELD_MASK = 32'((64'd1 << INC_W) - 64'd1);
  localparam logic [31:0] PERIOD_BIT = NARROW_INC ? (32'd1 << 24) : 32'd0;
  localparam logic [31:0] RST_INC    = NARROW_INC ?
                                       ((INC_10G >> NARROW_DROP) | PERIOD_BIT) : INC_10G;
  localparam logic [5:0]  RST_SHF    = NARROW_INC ? (SHF_10G - 6'(NARROW_DROP)) : SHF_10G;

  logic [1:0]       speed_q, src_speed;
  logic [PPB_W-1:0] ppb_q, src_ppb;
  logic [31:0]      inc_q, base, trimmed;
  logic [5:0]       shift_q, src_shift;
  logic             speed_chg;

  assign speed_chg = speed_i != speed_q;
  assign src_speed = speed_chg ? speed_i : speed_q;
  assign src_ppb   = ppb_we_i ? ppb_i : ppb_q;

  stc_inc_defaults #(.NARROW_INC(NARROW_INC)) u_defaults (
    .speed_i (src_speed),
    .base_o  (base),
    .shift_o (src_shift)
  );

  stc_ppb_trim #(.PPB_W(PPB_W)) u_trim (
    .base_i (base),
    .ppb_i  (src_ppb),
    .inc_o  (trimmed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q <= SPD_10G;
      ppb_q   <= '0;
      inc_q   <= RST_INC;
      shift_q <= RST_SHF;
    end else begin
      if (inc_we_i)                  inc_q <= (inc_wdata_i & FIELD_MASK) | PERIOD_BIT;
      else if (speed_chg || ppb_we_i) inc_q <= (trimmed & FIELD_MASK) | PERIOD_BIT;
      if (ppb_we_i)  ppb_q <= ppb_i;
      if (speed_chg) begin
        speed_q <= speed_i;
        shift_q <= src_shift;
      end
    end
  end

  stc_counter #(.TIME_W(TIME_W), .INC_W(INC_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (clr_i),
    .wr_lo_i (wr_lo_i),
    .wr_hi_i (wr_hi_i),
    .wdata_i (wdata_i),
    .inc_i   (inc_q),
    .rd_lo_i (rd_lo_i),
    .lo_o    (rd_lo_o),
    .hi_o    (rd_hi_o)
  );

  assign inc_o   = inc_q;
  assign shift_o = shift_q;

  AST_INC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_we_i && !ppb_we_i && !speed_chg) |=> $stable(inc_o)); // R7
  AST_TRIM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, trimmed} <= {1'b0, base} + {3'b0, base[31:2]} + 33'd1) &&
    ({1'b0, trimmed} + {3'b0, base[31:2]} + 33'd1 >= {1'b0, base})); // R6

  generate
    if (NARROW_INC) begin : g_period_chk
      AST_PERIOD_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_o[31:24] == 8'h01); // R4
    end
  endgenerate
endmodule

// File: tb/tb_sys_time_counter.sv
`timescale 1ns/1ps
module tb_sys_time_counter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  speed_i = 2'd0;
  logic        ppb_we_i = 1'b0;
  logic [31:0] ppb_i = '0;
  logic        inc_we_i = 1'b0;
  logic [31:0] inc_wdata_i = '0;
  logic        clr_i = 1'b0, wr_lo_i = 1'b0, wr_hi_i = 1'b0, rd_lo_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] lo_w, hi_w, inc_w, lo_n, hi_n, inc_n;
  logic [5:0]  shf_w, shf_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sys_time_counter #(.NARROW_INC(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .speed_i(speed_i),
    .ppb_we_i(ppb_we_i), .ppb_i(ppb_i), .inc_we_i(inc_we_i), .inc_wdata_i(inc_wdata_i),
    .clr_i(clr_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wdata_i(wdata_i),
    .rd_lo_i(rd_lo_i), .rd_lo_o(lo_w), .rd_hi_o(hi_w), .inc_o(inc_w), .shift_o(shf_w));

  sys_time_counter #(.NARROW_INC(1'b1)) dut_n (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .speed_i(speed_i),
    .ppb_we_i(ppb_we_i), .ppb_i(ppb_i), .inc_we_i(inc_we_i), .inc_wdata_i(inc_wdata_i),
    .clr_i(clr_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wdata_i(wdata_i),
    .rd_lo_i(rd_lo_i), .rd_lo_o(lo_n), .rd_hi_o(hi_n), .inc_o(inc_n), .shift_o(shf_n));

  // {speed, ppb, wide shift}
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 32'sd0,           6'd28},
    {2'd1, 32'sd0,           6'd24},
    {2'd2, 32'sd0,           6'd21},
    {2'd3, 32'sd0,           6'd28},
    {2'd0, 32'sd1000,        6'd28},
    {2'd0, -32'sd1000,       6'd28},
    {2'd1, 32'sd250000000,   6'd24},
    {2'd1, -32'sd300000000,  6'd24},
    {2'd2, 32'sd123456789,   6'd21},
    {2'd0, 32'sh7FFFFFFF,    6'd28},
    {2'd2, -32'sd250000000,  6'd21}
  };

  function automatic logic [31:0] exp_inc(bit narrow, logic [1:0] spd, logic signed [31:0] ppb);
    longint unsigned base, m, d, r;
    base = (spd == 2'd1) ? 64'h4000_0000 : (spd == 2'd2) ? 64'h5000_0000 : 64'h6666_6666;
    if (narrow) base = base >> 7;
    m = (ppb < 0) ? longint'(-longint'(ppb)) : longint'(ppb);
    if (m > 250000000) m = 250000000;
    d = (base * m) / 64'd1000000000;
    r = (ppb < 0) ? base - d : base + d;
    return narrow ? ((32'(r) & 32'h00FF_FFFF) | 32'h0100_0000) : (32'(r) & 32'h7FFF_FFFF);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd64(output logic [63:0] vw, output logic [63:0] vn);
    rd_lo_i = 1'b1; cyc(); rd_lo_i = 1'b0;
    vw = {hi_w, lo_w}; vn = {hi_n, lo_n};
  endtask

  task automatic clear();
    clr_i = 1'b1; cyc(); clr_i = 1'b0;
  endtask

  task automatic set_mode(logic [1:0] spd, logic [31:0] ppb);
    speed_i = spd; ppb_i = ppb; ppb_we_i = 1'b1; cyc(); ppb_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] vw, vn, a, b;
    cyc(3); rst_ni = 1'b1; cyc();
    // R10 reset state
    chk("R10 inc", inc_w, 32'h6666_6666);
    chk("R10 shift", shf_w, 6'd28);
    chk("R10 lo", lo_w, 0);
    chk("R10 hi", hi_w, 0);
    chk("R4 reset narrow inc", inc_n, 32'h01CC_CCCC);
    chk("R4 reset narrow shift", shf_n, 6'd21);

    // R3 R5 R6 R4 R1 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] spd;
      logic [31:0] ppb;
      logic [5:0] shf;
      logic [31:0] ew, en;
      {spd, ppb, shf} = VEC[i];
      set_mode(spd, ppb);
      ew = exp_inc(1'b0, spd, ppb);
      en = exp_inc(1'b1, spd, ppb);
      chk($sformatf("R3/R5/R6 inc v%0d", i), inc_w, ew);
      chk($sformatf("R3 shift v%0d", i), shf_w, shf);
      chk($sformatf("R4 narrow inc v%0d", i), inc_n, en);
      chk($sformatf("R4 narrow shift v%0d", i), shf_n, shf - 6'd7);
      clear();
      tick_i = 1'b1; cyc(3); tick_i = 1'b0;
      rd64(vw, vn);
      chk($sformatf("R1 accum v%0d", i), vw, 64'(ew & 32'h7FFF_FFFF) * 3);
      chk($sformatf("R1 narrow accum v%0d", i), vn, 64'(en & 32'h00FF_FFFF) * 3);
    end

    // R1 idle hold
    cyc(4);
    rd64(a, b);
    chk("R1 hold", a, vw);

    // R2 wrap
    set_mode(2'd0, 32'd0);
    wdata_i = 32'hFFFF_FFF0; wr_lo_i = 1'b1; cyc(); wr_lo_i = 1'b0;
    wdata_i = 32'hFFFF_FFFF; wr_hi_i = 1'b1; cyc(); wr_hi_i = 1'b0;
    rd64(vw, vn);
    chk("R8 word writes", vw, 64'hFFFF_FFFF_FFFF_FFF0);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    rd64(vw, vn);
    chk("R2 wrap", vw, 64'h0000_0000_6666_6656);

    // R8 priority
    wdata_i = 32'h1234_5678; wr_lo_i = 1'b1; clr_i = 1'b1; cyc(); wr_lo_i = 1'b0; clr_i = 1'b0;
    rd64(vw, vn);
    chk("R8 clear beats write", vw, 0);
    wdata_i = 32'hABCD_0000; wr_lo_i = 1'b1; tick_i = 1'b1; cyc(); wr_lo_i = 1'b0; tick_i = 1'b0;
    rd64(vw, vn);
    chk("R8 write beats tick", vw, 64'h0000_0000_ABCD_0000);
    wdata_i = 32'h0000_0007; wr_hi_i = 1'b1; cyc(); wr_hi_i = 1'b0;
    rd64(vw, vn);
    chk("R8 hi only keeps lo", vw, 64'h0000_0007_ABCD_0000);

    // R9 snapshot held
    wdata_i = 32'd5; wr_hi_i = 1'b1; cyc(); wr_hi_i = 1'b0;
    rd64(vw, vn);
    wdata_i = 32'd9; wr_hi_i = 1'b1; cyc(); wr_hi_i = 1'b0;
    cyc();
    chk("R9 snapshot held", hi_w, 32'd5);
    rd64(vw, vn);
    chk("R9 new snapshot", hi_w, 32'd9);

    // R7 direct increment write
    inc_wdata_i = 32'hFFFF_FFFF; inc_we_i = 1'b1; ppb_i = 32'd500; ppb_we_i = 1'b1;
    cyc(); inc_we_i = 1'b0; ppb_we_i = 1'b0;
    chk("R7 wide write", inc_w, 32'h7FFF_FFFF);
    chk("R7 narrow write", inc_n, 32'h01FF_FFFF);
    clear();
    tick_i = 1'b1; cyc(2); tick_i = 1'b0;
    rd64(vw, vn);
    chk("R7 accum", vw, 64'h0000_0000_FFFF_FFFE);
    cyc(3);
    chk("R7 held", inc_w, 32'h7FFF_FFFF);
    set_mode(2'd0, 32'd0);
    chk("R7 recompute", inc_w, 32'h6666_6666);

    // R11 speed change mid-run
    clear();
    tick_i = 1'b1; cyc(2);
    speed_i = 2'd1; cyc();
    cyc(); tick_i = 1'b0;
    rd64(vw, vn);
    chk("R11 accum", vw, 64'h6666_6666 * 3 + 64'h4000_0000);
    chk("R11 shift", shf_w, 6'd24);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule